// File: doc/BRIEF.md
# Next-PC Sequencing Unit

This block holds the program counter of a 32-bit byte-addressed processor and chooses the address of the next instruction in each cycle. The datapath gives it the instruction word being executed, the result of its operand-equality compare and the value of the source register used by register jumps. From these the unit picks one of five selection kinds:

- `SEL_HOLD`: the PC keeps its value.
- `SEL_SEQ`: the PC moves on by four bytes.
- `SEL_BRANCH`: a taken conditional branch, relative to PC+4.
- `SEL_JUMP`: a jump into the current 256 MB region.
- `SEL_JREG`: a jump to the address in a register.

The selection is decoded again from the inputs every cycle. A stall always gives `SEL_HOLD`. Without a stall, the opcode and the compare result choose among `SEL_SEQ`, `SEL_BRANCH`, `SEL_JUMP` and `SEL_JREG`. The PC register loads the address of the chosen kind on the next rising clock edge.

The unit also supplies PC+4 to the register file, for link writes. It flags in the same cycle when control flow leaves the sequential path. It also flags a register jump whose target is not word aligned; in that case it clears the two low target bits. Instruction memory, register-file access and exception vectors are handled elsewhere.

Top module: `npc_sequencer`

## Requirements
- R1: While `rst_n` is low, `pc` is 0. Reset is asynchronous and active low.
- R2: `pc_plus4` always equals `pc`+4, modulo 2^32, so 0xFFFFFFFC wraps to 0. When not stalled, any instruction that is not a taken branch, jump or register jump makes `pc` equal to `pc_plus4` after the next rising edge. This covers opcode 0 with a funct other than 8, and loads and stores.
- R3: Opcode field `instr[31:26]` = 4 is the equal-branch and 5 is the not-equal-branch. The equal-branch is taken when `operands_equal` is 1; the not-equal-branch is taken when it is 0. A taken branch loads `pc_plus4` + (sign-extended `instr[15:0]` shifted left by 2); an untaken one loads `pc_plus4`.
- R4: The branch offset covers the full signed 16-bit word range, from -32768 to +32767 words, relative to PC+4.
- R5: Opcodes 2 (jump) and 3 (jump-and-link) load `{pc_plus4[31:28], instr[25:0], 2'b00}`.
- R6: Opcode 0 with funct `instr[5:0]` = 8 is a register jump. It loads `reg_target` with bits [1:0] forced to 0.
- R7: `misaligned` is 1, in the same cycle, exactly when an unstalled register jump has `reg_target[1:0]` not 0.
- R8: While `stall` is 1, `pc` keeps its value at the next edge whatever the instruction. During that cycle `redirect` and `misaligned` are both 0.
- R9: `redirect` is 1, in the same cycle, exactly when the next PC differs from `pc_plus4`. A branch with offset -1 therefore raises it, and a taken branch with offset 0 does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Hold the PC this cycle |
| instr | input | 32 | Instruction word being executed |
| operands_equal | input | 1 | Equality result of the two branch operands |
| reg_target | input | 32 | Source register value for register jumps |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | PC+4, used as the link value |
| redirect | output | 1 | Next PC is not PC+4 |
| misaligned | output | 1 | Register-jump target had nonzero low bits |

## Verification
`pc_plus4`, `redirect` and `misaligned` are combinational, so they are due in the same cycle as the inputs that cause them. The new `pc` is due one rising edge later.

The driver task applies its inputs at a falling edge and checks the combinational outputs half a nanosecond afterwards. It then pushes the expected PC into a queue. The monitor pops that value one nanosecond after the following rising edge, so each prediction is compared exactly one register stage after its stimulus.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int INSN_W    = 32;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;
    localparam int OFF_W     = 16;
    localparam int JFIELD_W  = 26;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OPC_JLINK   = 6'd3;
    localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0] FN_JREG     = 6'd8;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_SEQ,
        SEL_BRANCH,
        SEL_JUMP,
        SEL_JREG
    } pc_sel_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int INSN_WIDTH = INSN_W
) (
    input  logic [INSN_WIDTH-1:0] instr,
    input  logic                  operands_equal,
    input  logic                  stall,
    output pc_sel_e               sel
);

    localparam int OP_LSB = INSN_WIDTH - OP_W;

    logic [OP_W-1:0] opcode;
    logic [FN_W-1:0] funct;

    assign opcode = instr[INSN_WIDTH-1:OP_LSB];
    assign funct  = instr[FN_W-1:0];

    always_comb begin
        sel = SEL_SEQ;
        if (stall) begin
            sel = SEL_HOLD;
        end else begin
            unique case (opcode)
                OPC_BR_EQ:           sel = operands_equal ? SEL_BRANCH : SEL_SEQ;
                OPC_BR_NE:           sel = operands_equal ? SEL_SEQ : SEL_BRANCH;
                OPC_JUMP, OPC_JLINK: sel = SEL_JUMP;
                OPC_SPECIAL:         sel = (funct == FN_JREG) ? SEL_JREG : SEL_SEQ;
                default:             sel = SEL_SEQ;
            endcase
        end
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int ADDR_WIDTH = XLEN,
    parameter int INSN_WIDTH = INSN_W
) (
    input  logic [ADDR_WIDTH-1:0] pc_plus4,
    input  logic [INSN_WIDTH-1:0] instr,
    input  logic [ADDR_WIDTH-1:0] reg_target,
    output logic [ADDR_WIDTH-1:0] branch_tgt,
    output logic [ADDR_WIDTH-1:0] jump_tgt,
    output logic [ADDR_WIDTH-1:0] jreg_tgt,
    output logic                  jreg_unaligned
);

    localparam int BYTE_SH  = 2;
    localparam int EXT_W    = ADDR_WIDTH - OFF_W - BYTE_SH;
    localparam int REGION_W = ADDR_WIDTH - JFIELD_W - BYTE_SH;

    logic [OFF_W-1:0]      offset;
    logic [ADDR_WIDTH-1:0] offset_bytes;

    assign offset       = instr[OFF_W-1:0];
    assign offset_bytes = {{EXT_W{offset[OFF_W-1]}}, offset, {BYTE_SH{1'b0}}};
    assign branch_tgt   = pc_plus4 + offset_bytes;

    generate
        if (REGION_W > 0) begin : g_region
            assign jump_tgt = {pc_plus4[ADDR_WIDTH-1:ADDR_WIDTH-REGION_W],
                               instr[JFIELD_W-1:0], {BYTE_SH{1'b0}}};
        end else begin : g_flat
            assign jump_tgt = {instr[ADDR_WIDTH-BYTE_SH-1:0], {BYTE_SH{1'b0}}};
        end
    endgenerate

    assign jreg_tgt       = {reg_target[ADDR_WIDTH-1:BYTE_SH], {BYTE_SH{1'b0}}};
    assign jreg_unaligned = |reg_target[BYTE_SH-1:0];

endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
    import npc_pkg::*;
#(
    parameter int ADDR_WIDTH = XLEN,
    parameter int INSN_WIDTH = INSN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stall,
    input  logic [INSN_WIDTH-1:0] instr,
    input  logic                  operands_equal,
    input  logic [ADDR_WIDTH-1:0] reg_target,
    output logic [ADDR_WIDTH-1:0] pc,
    output logic [ADDR_WIDTH-1:0] pc_plus4,
    output logic                  redirect,
    output logic                  misaligned
);

    localparam logic [ADDR_WIDTH-1:0] STEP     = ADDR_WIDTH'(4);
    localparam logic [ADDR_WIDTH-1:0] RESET_PC = '0;

    pc_sel_e               sel;
    logic [ADDR_WIDTH-1:0] pc_q;
    logic [ADDR_WIDTH-1:0] pc_next;
    logic [ADDR_WIDTH-1:0] branch_tgt;
    logic [ADDR_WIDTH-1:0] jump_tgt;
    logic [ADDR_WIDTH-1:0] jreg_tgt;
    logic                  jreg_unaligned;
    logic                  left_seq;

    assign pc_plus4 = pc_q + STEP;
    assign pc       = pc_q;

    npc_decode #(.INSN_WIDTH(INSN_WIDTH)) decode_i (
        .instr          (instr),
        .operands_equal (operands_equal),
        .stall          (stall),
        .sel            (sel)
    );

    npc_target #(.ADDR_WIDTH(ADDR_WIDTH), .INSN_WIDTH(INSN_WIDTH)) target_i (
        .pc_plus4       (pc_plus4),
        .instr          (instr),
        .reg_target     (reg_target),
        .branch_tgt     (branch_tgt),
        .jump_tgt       (jump_tgt),
        .jreg_tgt       (jreg_tgt),
        .jreg_unaligned (jreg_unaligned)
    );

    // PC register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    // Next-address selection and flags
    always_comb begin
        pc_next  = pc_plus4;
        left_seq = 1'b0;
        unique case (sel)
            SEL_HOLD:   pc_next = pc_q;
            SEL_SEQ:    pc_next = pc_plus4;
            SEL_BRANCH: begin pc_next = branch_tgt; left_seq = 1'b1; end
            SEL_JUMP:   begin pc_next = jump_tgt;   left_seq = 1'b1; end
            SEL_JREG:   begin pc_next = jreg_tgt;   left_seq = 1'b1; end
            default:    pc_next = pc_plus4;
        endcase
        redirect   = left_seq && (pc_next != pc_plus4);
        misaligned = (sel == SEL_JREG) && jreg_unaligned;
    end

endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        stall,
    input logic [31:0] instr,
    input logic        operands_equal,
    input logic [31:0] reg_target,
    input logic [31:0] pc,
    input logic [31:0] pc_plus4,
    input logic        redirect,
    input logic        misaligned
);

    logic is_jreg;
    assign is_jreg = (instr[31:26] == 6'd0) && (instr[5:0] == 6'd8);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_zero_r1: assert (pc == 32'd0)
                else $error("pc not zero during reset");
        end
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect) |=> (pc == $past(pc) + 32'd4));

    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    p_beq_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && instr[31:26] == 6'd4 && operands_equal) |=>
        (pc == $past(pc_plus4) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    p_jump_region_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && (instr[31:26] == 6'd2 || instr[31:26] == 6'd3)) |=>
        (pc == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00}));

    p_jreg_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && is_jreg) |=> (pc == {$past(reg_target[31:2]), 2'b00}));

    p_misalign_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (!stall && is_jreg && reg_target[1:0] != 2'b00));

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    p_stall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!redirect && !misaligned));

    p_redirect_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc != $past(pc_plus4)));

endmodule

bind npc_sequencer npc_sequencer_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall          (stall),
    .instr          (instr),
    .operands_equal (operands_equal),
    .reg_target     (reg_target),
    .pc             (pc),
    .pc_plus4       (pc_plus4),
    .redirect       (redirect),
    .misaligned     (misaligned)
);

// File: tb/npc_sequencer_tb_top.sv
`timescale 1ns/100ps
module npc_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [31:0] instr;
    logic        operands_equal;
    logic [31:0] reg_target;
    logic [31:0] pc;
    logic [31:0] pc_plus4;
    logic        redirect;
    logic        misaligned;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] m_pc;
    logic [31:0] exp_pc_q[$];
    string       exp_tag_q[$];

    always #2.5 clk = ~clk;

    npc_sequencer dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .stall          (stall),
        .instr          (instr),
        .operands_equal (operands_equal),
        .reg_target     (reg_target),
        .pc             (pc),
        .pc_plus4       (pc_plus4),
        .redirect       (redirect),
        .misaligned     (misaligned)
    );

    function automatic logic [31:0] mk_i(logic [5:0] op, logic [15:0] imm);
        return {op, 10'd0, imm};
    endfunction

    function automatic logic [31:0] mk_j(logic [5:0] op, logic [25:0] fld);
        return {op, fld};
    endfunction

    function automatic logic [31:0] mk_r(logic [5:0] fn);
        return {26'd0, fn};
    endfunction

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus, checks same-cycle outputs,
    // queues the PC expected after the next rising edge.
    task automatic step(string tag, logic [31:0] ins, logic eq, logic [31:0] rt, logic stl);
        logic [31:0] p4;
        logic [31:0] nxt;
        logic        taken;
        logic        mis;
        @(negedge clk);
        instr = ins; operands_equal = eq; reg_target = rt; stall = stl;
        p4 = m_pc + 32'd4; nxt = p4; taken = 1'b0; mis = 1'b0;
        if (stl) begin
            nxt = m_pc;
        end else begin
            case (ins[31:26])
                6'd4: if (eq)  begin taken = 1'b1; nxt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00}; end
                6'd5: if (!eq) begin taken = 1'b1; nxt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00}; end
                6'd2, 6'd3: begin taken = 1'b1; nxt = {p4[31:28], ins[25:0], 2'b00}; end
                6'd0: if (ins[5:0] == 6'd8) begin
                    taken = 1'b1; nxt = {rt[31:2], 2'b00}; mis = |rt[1:0];
                end
                default: ;
            endcase
        end
        #0.5;
        check32(tag, "pc_plus4", pc_plus4, p4);
        check1(tag, "redirect", redirect, taken && (nxt != p4));
        check1(tag, "misaligned", misaligned, mis);
        exp_pc_q.push_back(nxt);
        exp_tag_q.push_back(tag);
        m_pc = nxt;
    endtask

    // Monitor: compares the registered PC one edge after each stimulus.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_pc_q.size() > 0) begin
                logic [31:0] e;
                string       t;
                e = exp_pc_q.pop_front();
                t = exp_tag_q.pop_front();
                check32(t, "pc", pc, e);
            end
        end
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; stall = 1'b1; instr = '0; operands_equal = 1'b0;
        reg_target = '0; m_pc = '0;
        repeat (3) @(posedge clk);
        #1;
        check32("R1", "pc in reset", pc, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R2 nop",             mk_r(6'd0), 1'b0, 32'd0, 1'b0);
        step("R2 load",            32'h8C00_0000, 1'b1, 32'd0, 1'b0);
        step("R3 beq taken",       mk_i(6'd4, 16'd3), 1'b1, 32'd0, 1'b0);
        step("R3 beq not taken",   mk_i(6'd4, 16'd3), 1'b0, 32'd0, 1'b0);
        step("R3 bne taken back",  mk_i(6'd5, 16'hFFFE), 1'b0, 32'd0, 1'b0);
        step("R3 bne not taken",   mk_i(6'd5, 16'hFFFE), 1'b1, 32'd0, 1'b0);
        step("R9 offset -1",       mk_i(6'd4, 16'hFFFF), 1'b1, 32'd0, 1'b0);
        step("R9 offset 0",        mk_i(6'd4, 16'h0000), 1'b1, 32'd0, 1'b0);
        step("R5 jump",            mk_j(6'd2, 26'h0000100), 1'b0, 32'd0, 1'b0);
        step("R6 jreg aligned",    mk_r(6'd8), 1'b0, 32'hF000_0000, 1'b0);
        step("R5 jal region",      mk_j(6'd3, 26'h3FF_FFFF), 1'b0, 32'd0, 1'b0);
        step("R2 wrap",            mk_r(6'd0), 1'b0, 32'd0, 1'b0);
        step("R7 jreg misaligned", mk_r(6'd8), 1'b0, 32'h0000_1003, 1'b0);
        step("R8 stall jreg",      mk_r(6'd8), 1'b0, 32'h0000_2002, 1'b1);
        step("R8 stall jump",      mk_j(6'd2, 26'h0000040), 1'b0, 32'd0, 1'b1);
        step("R4 max forward",     mk_i(6'd4, 16'h7FFF), 1'b1, 32'd0, 1'b0);
        step("R6 jreg",            mk_r(6'd8), 1'b0, 32'h0004_0000, 1'b0);
        step("R4 max backward",    mk_i(6'd5, 16'h8000), 1'b0, 32'd0, 1'b0);
        step("R2 other funct",     mk_r(6'd32), 1'b1, 32'h0000_0003, 1'b0);
        step("R8 stall beq",       mk_i(6'd4, 16'd5), 1'b1, 32'd0, 1'b1);
        step("R2 after stall",     mk_r(6'd0), 1'b0, 32'd0, 1'b0);

        @(negedge clk);
        stall = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule